// File: doc/BRIEF.md
# Four-Channel Dithered DAC Driver

This block feeds four 8-bit DAC channels from one core, and every channel takes its new code on the same rising clock edge. In shifter mode a single 32-bit word carries all four codes, one byte per channel. The byte lanes always have a fixed video meaning: red in the top byte, then green, then blue, with horizontal sync in the bottom byte. The block does no colour modulation and no colour-space conversion.

In direct mode each channel holds a 16-bit value, written by software. The top byte of that value is the coarse DAC code. The bottom byte drives an 8-bit error accumulator. Each time the accumulator carries out, the code for that clock goes up by one, so over 256 clocks the average code follows the full 16-bit value. Pixel timing is left to the logic around the block.

Top module: `dac4_shifter`

## Requirements
- R1: While `rst_n` is low, all four outputs are zero and every dither accumulator and stored direct value is cleared.
- R2: When `mode` is 0 and `load` is 1 at a rising edge, the outputs show the captured word after that edge. The mapping is `load_word[31:24]` to `dac_red`, `[23:16]` to `dac_grn`, `[15:8]` to `dac_blu` and `[7:0]` to `dac_hsy`.
- R3: When `mode` is 0 and `load` is 0, all four outputs keep their values.
- R4: All four channels change on the same edge, each from its own byte or value.
- R5: When `mode` is 1, at each edge where a channel is not written, its accumulator adds the low byte of that channel's value. The channel's output becomes the high byte plus the carry out of that 8-bit addition.
- R6: In direct mode the output saturates at 255. It never wraps when the high byte is 255 and a carry occurs.
- R7: Take the 256 edges that follow a write of value V, in direct mode and with no other write. The outputs over those edges sum to exactly V, provided the high byte of V is below 255.
- R8: A write pulse on `direct_wr[k]` stores `direct_val[16k+15:16k]` and restarts channel k's accumulator at zero. In direct mode, the output of that channel after the write edge equals the high byte of the new value. Lane k is 3 for red, 2 for green, 1 for blue and 0 for hsync.
- R9: In direct mode, `load` and `load_word` have no effect on the outputs.
- R10: In shifter mode, direct writes store the value and clear the accumulator but leave the outputs unchanged. The accumulators do not advance while `mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = shifter mode, 1 = direct dithered mode |
| load | input | 1 | Strobe that captures load_word in shifter mode |
| load_word | input | 32 | Four packed channel codes, red in the top byte |
| direct_wr | input | 4 | Per-lane write strobe for direct values |
| direct_val | input | 64 | Four 16-bit direct values, lane k at bits 16k+15:16k |
| dac_red | output | 8 | DAC code, lane 3 |
| dac_grn | output | 8 | DAC code, lane 2 |
| dac_blu | output | 8 | DAC code, lane 1 |
| dac_hsy | output | 8 | DAC code, lane 0 |

## Verification
A corrupted accumulator does not show up as a wrong level. It shows up as carries in the wrong cycles. The first misplaced carry moves one output by a single code on the very next edge, so a per-edge scoreboard that follows the accumulator model catches it at once. A lost or extra carry also changes the 256-edge sum of a channel, and a wrong restart on write shifts that sum by up to the low byte. A mapping error between lanes appears on the first edge after a shifter load that uses four distinct bytes.

// File: rtl/dac4_pkg.sv
package dac4_pkg;
  parameter int NUM_CH = 4;
  parameter int CODE_W = 8;
  parameter int FRAC_W = 8;
  localparam int VAL_W  = CODE_W + FRAC_W;
  localparam int WORD_W = NUM_CH * CODE_W;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [VAL_W-1:0]  val_t;
endpackage

// File: rtl/dac4_word_split.sv
module dac4_word_split
  import dac4_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output code_t             lane_byte [NUM_CH]
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    assign lane_byte[k] = word[k*CODE_W +: CODE_W];
  end
endmodule

// File: rtl/dac4_dither_lane.sv
module dac4_dither_lane
  import dac4_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  wr,
  input  val_t  wval,
  output code_t code_nxt
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  val_t                val_q, val_d;
  logic [FRAC_W-1:0]   acc_q, acc_d;
  logic [FRAC_W:0]     sum;
  logic [CODE_W:0]     hi_inc;
  code_t               sat_code;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, val_q[FRAC_W-1:0]};
    hi_inc   = {1'b0, val_q[VAL_W-1:FRAC_W]} + {{CODE_W{1'b0}}, sum[FRAC_W]};
    sat_code = hi_inc[CODE_W] ? CODE_MAX : hi_inc[CODE_W-1:0];
    val_d    = val_q;
    acc_d    = acc_q;
    code_nxt = sat_code;
    if (wr) begin
      val_d    = wval;
      acc_d    = '0;
      code_nxt = wval[VAL_W-1:FRAC_W];
    end else if (run) begin
      acc_d    = sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      acc_q <= '0;
    end else begin
      val_q <= val_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/dac4_shifter.sv
module dac4_shifter
  import dac4_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode,
  input  logic        load,
  input  logic [31:0] load_word,
  input  logic [3:0]  direct_wr,
  input  logic [63:0] direct_val,
  output logic [7:0]  dac_red,
  output logic [7:0]  dac_grn,
  output logic [7:0]  dac_blu,
  output logic [7:0]  dac_hsy
);
  code_t lane_byte [NUM_CH];
  code_t lane_dith [NUM_CH];
  code_t out_q     [NUM_CH];
  code_t out_d     [NUM_CH];

  dac4_word_split u_split (
    .word      (load_word),
    .lane_byte (lane_byte)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    dac4_dither_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (mode),
      .wr       (direct_wr[k]),
      .wval     (direct_val[k*VAL_W +: VAL_W]),
      .code_nxt (lane_dith[k])
    );

    always_comb begin
      out_d[k] = out_q[k];
      if (mode)      out_d[k] = lane_dith[k];
      else if (load) out_d[k] = lane_byte[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[k] <= '0;
      else        out_q[k] <= out_d[k];
    end
  end

  assign dac_red = out_q[3];
  assign dac_grn = out_q[2];
  assign dac_blu = out_q[1];
  assign dac_hsy = out_q[0];
endmodule

// File: rtl/dac4_shifter_chk.sv
module dac4_shifter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode,
  input logic        load,
  input logic [31:0] load_word,
  input logic [3:0]  direct_wr,
  input logic [63:0] direct_val,
  input logic [7:0]  dac_red,
  input logic [7:0]  dac_grn,
  input logic [7:0]  dac_blu,
  input logic [7:0]  dac_hsy
);
  wire [31:0] outs = {dac_red, dac_grn, dac_blu, dac_hsy};

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> outs == 32'h0);

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && load) |=> outs == $past(load_word));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !load) |=> $stable(outs));

  a_r8_restart_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && direct_wr[3]) |=> dac_red == $past(direct_val[63:56]));

  a_r5_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && $past(mode) && !direct_wr[3] && !$past(direct_wr[3]))
    |=> ((dac_red - $past(dac_red)) <= 8'd1 || ($past(dac_red) - dac_red) <= 8'd1));
endmodule

bind dac4_shifter dac4_shifter_chk u_chk (.*);

// File: tb/dac4_shifter_test.sv
`timescale 1ns/1ps
module dac4_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode, load;
  logic [31:0] load_word;
  logic [3:0]  direct_wr;
  logic [63:0] direct_val;
  logic [7:0]  dac_red, dac_grn, dac_blu, dac_hsy;

  always #2.5 clk = ~clk;

  dac4_shifter uut (.*);

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  logic [15:0] mval [4];
  logic [7:0]  macc [4];
  logic [7:0]  mout [4];
  bit          done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0)
      check(tag_q.pop_front(), {dac_red, dac_grn, dac_blu, dac_hsy}, exp_q.pop_front());
  end

  task automatic step(input logic m, input logic ld, input logic [31:0] w,
                      input logic [3:0] wr, input logic [63:0] v, input string tag);
    @(negedge clk);
    mode = m; load = ld; load_word = w; direct_wr = wr; direct_val = v;
    for (int k = 0; k < 4; k++) begin
      logic [8:0] s;
      logic [8:0] h;
      logic [15:0] nv;
      nv = v[16*k +: 16];
      s = {1'b0, macc[k]} + {1'b0, mval[k][7:0]};
      h = {1'b0, mval[k][15:8]} + {8'd0, s[8]};
      if (m) mout[k] = wr[k] ? nv[15:8] : (h > 9'd255 ? 8'd255 : h[7:0]);
      else if (ld) mout[k] = w[8*k +: 8];
      if (wr[k]) begin mval[k] = nv; macc[k] = 8'd0; end
      else if (m) macc[k] = s[7:0];
    end
    exp_q.push_back({mout[3], mout[2], mout[1], mout[0]});
    tag_q.push_back(tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int sum;
    rst_n = 1'b0; mode = 0; load = 0; load_word = 0; direct_wr = 0; direct_val = 0;
    for (int k = 0; k < 4; k++) begin mval[k] = 0; macc[k] = 0; mout[k] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {dac_red, dac_grn, dac_blu, dac_hsy}, 32'h0);
    rst_n = 1'b1;
    // R1: first direct cycles start from cleared accumulators and values
    step(1, 0, 0, 4'h0, 0, "R1 cleared state");
    step(0, 0, 0, 4'h0, 0, "R1 cleared state");
    // R2 R4: byte lanes, all at once
    step(0, 1, 32'hA1B2C3D4, 4'h0, 0, "R2 R4 shifter load");
    step(0, 0, 32'h11111111, 4'h0, 0, "R3 hold");
    step(0, 0, 32'h22222222, 4'h0, 0, "R3 hold");
    step(0, 1, 32'h00FF7F80, 4'h0, 0, "R2 second load");
    // R10: writes in shifter mode leave outputs alone
    step(0, 0, 0, 4'hF, {16'h1280, 16'h0040, 16'hFFFF, 16'h7F01}, "R10 write in shifter");
    step(0, 0, 0, 4'h0, 0, "R10 idle accumulators");
    step(0, 0, 0, 4'h0, 0, "R10 idle accumulators");
    // R5 R6 R9: direct dither, load ignored
    for (int i = 0; i < 20; i++)
      step(1, i[0], 32'hDEADBEEF, 4'h0, 0, "R5 R6 R9 direct dither");
    // R7: 256-edge mean on red after restart
    step(1, 0, 0, 4'hF, {16'h1280, 16'h0040, 16'hFFFF, 16'h7F01}, "R8 restart write");
    sum = 0;
    for (int i = 0; i < 256; i++) begin
      step(1, 1, 32'h55AA55AA, 4'h0, 0, "R5 R6 R9 direct run");
      @(posedge clk); #1;
      sum += dac_red + dac_hsy * 65536;
    end
    check("R7 red mean", sum % 65536, 32'h1280);
    check("R7 hsync mean", sum / 65536, 32'h7F01);
    // R6: saturated lane stays at top
    check("R6 saturation", {24'd0, dac_blu}, 32'hFF);
    // R8: restart mid-run with new values
    step(1, 0, 0, 4'h9, {16'h03C0, 16'h0, 16'h0, 16'h00FF}, "R8 restart mid-run");
    for (int i = 0; i < 12; i++)
      step(1, 0, 0, 4'h0, 0, "R8 R5 after restart");
    step(0, 0, 0, 4'h0, 0, "R3 hold after direct");
    step(0, 1, 32'h01020304, 4'h0, 0, "R2 R4 load after direct");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule